// File: doc/BRIEF.md
# Register Extend-and-Shift Operand Unit

This combinational unit prepares the second operand of a 64-bit integer datapath. It takes a source register value, picks out a low field of 8, 16, 32 or 64 bits, zero-extends or sign-extends that field, and shifts it left by 0 to 4 places. The result is then limited to the operating width of the instruction, which is either 32 or 64 bits.

The field length is limited to the room left once the shift is applied. The effective length is the smaller of the nominal length and (operating width minus shift). Sign extension copies bit (effective length + shift - 1) of the shifted value, so the sign is read after the shift, not before it. A shift amount outside 0..4 sets an error flag, and the unit then treats the shift as zero.

Top module: `esu_operand`

## Requirements
- R1: When `ext_type_i[2]` is 0, the field is zero-extended. The field length is set by `ext_type_i[1:0]`: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Every output bit above (effective length + shift) is 0.
- R2: When `ext_type_i[2]` is 1, bit (effective length + shift - 1) of the shifted field is copied into every higher bit up to the operating width.
- R3: A shift amount of 0 to 4 moves the field left by that many places, and the low bits that are vacated read 0.
- R4: The effective field length is min(nominal length, operating width - shift). Source bits at or above that length do not reach the output.
- R5: When `wide_i` is 0 the operating width is 32, and `opnd_o[63:32]` is always 0. When `wide_i` is 1 the operating width is 64.
- R6: A shift amount above 4 drives `shamt_err_o` high, and the output is the same as for a shift of 0.
- R7: `shamt_err_o` is low for every shift amount from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Source register value |
| ext_type_i | input | 3 | Bit 2 selects signed; bits 1:0 select the byte, halfword, word or doubleword field |
| shamt_i | input | 3 | Left shift amount; legal range 0..4 |
| wide_i | input | 1 | 1 selects 64-bit operating width, 0 selects 32-bit |
| opnd_o | output | 64 | Extended, shifted and masked operand |
| shamt_err_o | output | 1 | High when the shift amount is above 4 |

## Verification
The immediate assertions assume the inputs are settled, two-state values each time the combinational logic is evaluated. The assertions are only meaningful once every input holds a defined value. The bench therefore gives every input a known value at declaration, changes inputs only between samples, and reads the outputs one time unit after each change. The stimulus covers all eight extend types, every legal shift, both widths and each of the three illegal shift codes. This keeps every encoding the assertions decode within the range the requirements define.

// File: rtl/esu_pkg.sv
package esu_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned LEN_W = $clog2(XLEN) + 1;
  localparam int unsigned SH_W  = 3;
  localparam int unsigned SH_MAX = 4;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} fsize_e;

  typedef struct packed {
    logic   is_signed;
    fsize_e size;
  } ext_t;

  // Nominal field length in bits for a size code.
  function automatic logic [LEN_W-1:0] size_bits(fsize_e s);
    return LEN_W'(8) << s;
  endfunction

  // Low n bits set; n may equal XLEN.
  function automatic logic [XLEN-1:0] low_ones(logic [LEN_W-1:0] n);
    if (n >= LEN_W'(XLEN)) return '1;
    return (XLEN'(1) << n) - XLEN'(1);
  endfunction
endpackage

// File: rtl/esu_len_sel.sv
module esu_len_sel
  import esu_pkg::*;
(
  input  fsize_e            size_i,
  input  logic [SH_W-1:0]   shamt_raw_i,
  input  logic              wide_i,
  output logic [SH_W-1:0]   shamt_o,
  output logic [LEN_W-1:0]  eff_len_o,
  output logic [LEN_W-1:0]  top_pos_o,
  output logic [LEN_W-1:0]  op_width_o,
  output logic              shamt_err_o
);
  logic [LEN_W-1:0] nominal;
  logic [LEN_W-1:0] room;

  always_comb begin
    shamt_err_o = (shamt_raw_i > SH_W'(SH_MAX));
    shamt_o     = shamt_err_o ? '0 : shamt_raw_i;
    op_width_o  = wide_i ? LEN_W'(XLEN) : LEN_W'(XLEN / 2);
    nominal     = size_bits(size_i);
    room        = op_width_o - LEN_W'(shamt_o);
    eff_len_o   = (nominal <= room) ? nominal : room;
    top_pos_o   = eff_len_o + LEN_W'(shamt_o);
  end

  always_comb begin
    assert_fits_width_R4: assert (top_pos_o <= op_width_o);
    assert_bad_shift_zero_R6: assert (!shamt_err_o || shamt_o == '0);
    assert_legal_shift_R7: assert ((shamt_raw_i > SH_W'(SH_MAX)) || shamt_o == shamt_raw_i);
  end
endmodule

// File: rtl/esu_extend.sv
module esu_extend
  import esu_pkg::*;
(
  input  logic [XLEN-1:0]   src_i,
  input  logic              is_signed_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [LEN_W-1:0]  eff_len_i,
  input  logic [LEN_W-1:0]  top_pos_i,
  input  logic [LEN_W-1:0]  op_width_i,
  output logic [XLEN-1:0]   result_o
);
  logic [XLEN-1:0] shifted;
  logic            sign_bit;
  logic            fill;

  always_comb begin
    shifted  = (src_i & low_ones(eff_len_i)) << shamt_i;
    sign_bit = shifted[top_pos_i - LEN_W'(1)];
    fill     = is_signed_i & sign_bit;
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    localparam logic [LEN_W-1:0] POS = LEN_W'(i);
    assign result_o[i] = (POS < op_width_i) &&
                         ((POS >= top_pos_i) ? fill : shifted[i]);
  end
endmodule

// File: rtl/esu_operand.sv
module esu_operand
  import esu_pkg::*;
(
  input  logic [63:0] src_i,
  input  logic [2:0]  ext_type_i,
  input  logic [2:0]  shamt_i,
  input  logic        wide_i,
  output logic [63:0] opnd_o,
  output logic        shamt_err_o
);
  ext_t             ext;
  logic [SH_W-1:0]  shamt_eff;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] top_pos;
  logic [LEN_W-1:0] op_width;

  assign ext = ext_t'(ext_type_i);

  esu_len_sel u_len (
    .size_i      (ext.size),
    .shamt_raw_i (shamt_i),
    .wide_i      (wide_i),
    .shamt_o     (shamt_eff),
    .eff_len_o   (eff_len),
    .top_pos_o   (top_pos),
    .op_width_o  (op_width),
    .shamt_err_o (shamt_err_o)
  );

  esu_extend u_ext (
    .src_i       (src_i),
    .is_signed_i (ext.is_signed),
    .shamt_i     (shamt_eff),
    .eff_len_i   (eff_len),
    .top_pos_i   (top_pos),
    .op_width_i  (op_width),
    .result_o    (opnd_o)
  );

  always_comb begin
    assert_low_zero_R3: assert ((opnd_o & low_ones(LEN_W'(shamt_eff))) == '0);
    assert_narrow_upper_R5: assert (wide_i || opnd_o[63:32] == 32'h0);
    assert_unsigned_clear_R1: assert (ext.is_signed ||
                                      (opnd_o & ~low_ones(top_pos)) == '0);
    assert_sign_fill_R2: assert (!ext.is_signed || top_pos == op_width ||
                                 opnd_o[op_width - LEN_W'(1)] == opnd_o[top_pos - LEN_W'(1)]);
  end
endmodule

// File: tb/esu_operand_bench.sv
module esu_operand_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic [2:0]  typ = '0;
  logic [2:0]  sh  = '0;
  logic        wide = 1'b1;
  logic [63:0] opnd;
  logic        err;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  esu_operand u_esu_operand (
    .src_i(src), .ext_type_i(typ), .shamt_i(sh), .wide_i(wide),
    .opnd_o(opnd), .shamt_err_o(err)
  );

  // Bit-by-bit model: output bit i takes source bit (i - shift) while inside
  // the field, the field's top source bit (signed) or 0 above it.
  function automatic logic [63:0] model(logic [63:0] s, logic [2:0] t,
                                        logic [2:0] a, logic w);
    int amt = (a > 4) ? 0 : int'(a);
    int ow  = w ? 64 : 32;
    int len = 8 << t[1:0];
    logic [63:0] r = '0;
    if (len > ow - amt) len = ow - amt;
    for (int i = 0; i < ow; i++) begin
      if (i < amt)            r[i] = 1'b0;
      else if (i - amt < len) r[i] = s[i - amt];
      else                    r[i] = t[2] & s[len - 1];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] s, logic [2:0] t, logic [2:0] a, logic w);
    @(negedge clk);
    src = s; typ = t; sh = a; wide = w;
    #1;
  endtask

  task automatic t_reset;
    apply('0, 3'd0, 3'd0, 1'b1);
    chk("R1 zero input", opnd, 64'h0);
    chk("R7 zero input err", {63'h0, err}, 64'h0);
  endtask

  task automatic t_unsigned_R1;
    for (int t = 0; t < 4; t++) begin
      apply(64'hF0E1_D2C3_B4A5_9687, 3'(t), 3'd0, 1'b1);
      chk("R1 unsigned size", opnd, model(src, typ, sh, wide));
    end
    apply(64'hFFFF_FFFF_FFFF_FF80, 3'd0, 3'd0, 1'b1);
    chk("R1 byte zero-extend", opnd, 64'h80);
  endtask

  task automatic t_signed_R2;
    apply(64'h0000_0000_0000_00FF, 3'd4, 3'd4, 1'b1);
    chk("R2 signed byte shift 4", opnd, 64'hFFFF_FFFF_FFFF_FFF0);
    apply(64'h0000_0000_0000_7FFF, 3'd5, 3'd0, 1'b1);
    chk("R2 positive half", opnd, 64'h7FFF);
    for (int t = 4; t < 8; t++) begin
      apply(64'h8765_4321_8765_8321, 3'(t), 3'd1, 1'b1);
      chk("R2 signed size", opnd, model(src, typ, sh, wide));
    end
  endtask

  task automatic t_shift_R3;
    for (int a = 0; a <= 4; a++) begin
      apply(64'h0000_0000_0000_ABCD, 3'd1, 3'(a), 1'b1);
      chk("R3 shift", opnd, 64'hABCD << a);
      chk("R7 legal err", {63'h0, err}, 64'h0);
    end
  endtask

  task automatic t_clamp_R4;
    apply(64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 3'd3, 1'b1);
    chk("R4 dword clamp", opnd, 64'hFFFF_FFFF_FFFF_FFF8);
    apply(64'h0000_0000_2000_0000, 3'd6, 3'd2, 1'b0);
    chk("R4 word narrow sign", opnd, 64'h0000_0000_8000_0000);
    apply(64'h0000_0000_1000_0000, 3'd7, 3'd3, 1'b0);
    chk("R4 dword narrow sign", opnd, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_narrow_R5;
    apply(64'h0000_0000_0000_0080, 3'd4, 3'd0, 1'b0);
    chk("R5 narrow sign byte", opnd, 64'h0000_0000_FFFF_FF80);
    for (int t = 0; t < 8; t++) begin
      apply(64'hDEAD_BEEF_CAFE_F00D, 3'(t), 3'd2, 1'b0);
      chk("R5 narrow upper zero", {32'h0, opnd[63:32]}, 64'h0);
      chk("R5 narrow model", opnd, model(src, typ, sh, wide));
    end
  endtask

  task automatic t_bad_R6;
    for (int a = 5; a < 8; a++) begin
      apply(64'h0000_0000_0000_00C3, 3'd4, 3'(a), 1'b1);
      chk("R6 bad shift err", {63'h0, err}, 64'h1);
      chk("R6 bad shift as zero", opnd, 64'hFFFF_FFFF_FFFF_FFC3);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_unsigned_R1();
    t_signed_R2();
    t_shift_R3();
    t_clamp_R4();
    t_narrow_R5();
    t_bad_R6();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule